// File: doc/BRIEF.md
# PCM/TDM serial audio port

This block is the data side of a four-wire pulse-code-modulation audio link: a bit clock, a frame sync, a transmit line and a receive line. The port is a timing slave. An external master drives the bit clock and a sync pulse one bit clock wide at the sample rate. The block oversamples all three incoming wires with its own system clock, finds the bit-clock edges, counts bit positions and time slots from the sync, and exchanges one parallel frame of samples per sample period with the rest of the chip. Several devices share the lines by time-division multiplexing. Each port drives the transmit line only in the slots it owns and releases it, through an output enable, in all other slots.

Configuration inputs set four things: whether the first bit of a frame coincides with the sync pulse or follows it by one bit clock, the number of slots per frame, the slot width, and one mask each for the transmit and receive slots owned. These inputs must be held steady while the link runs. Both frame interfaces use valid/ready. On transmit, one frame is held in a holding register. `tx_ready_o` is high only while that register is empty. At each frame start the held frame moves to the shift stage, which frees the register again. If no frame is waiting, the owned slots carry zeros. On receive, `rx_valid_o` rises after the last bit of a complete frame and stays high until `rx_ready_i` is seen. Receive never stalls the link: a frame that completes while the previous one is still pending replaces it.

Top module: `pcm_tdm_port`

## Requirements
- R1: While reset is held and right after it, `txd_oe_o`, `txd_o`, `rx_valid_o` and `sync_err_o` are 0 and `tx_ready_o` is 1.
- R2: With `cfg_align_b_i` = 1, the bit sampled on the rising bit-clock edge where sync is high is the MSB of slot 0.
- R3: With `cfg_align_b_i` = 0, the sync high on a rising edge marks the last bit of the previous frame, and the MSB of slot 0 is sampled on the next rising edge.
- R4: A frame holds `cfg_slots_m1_i`+1 slots numbered from 0 after the sync, each `cfg_bits_m1_i`+1 bits, MSB first. The sample of slot s sits in bits [s*MAX_W +: MAX_W] of the frame vectors, right-aligned.
- R5: `txd_o` and `txd_oe_o` change only after a detected falling bit-clock edge, so each bit is stable across the next rising edge.
- R6: Once the first sync has been seen, `txd_oe_o` is 1 exactly in slots whose bit in `cfg_tx_mask_i` is set. It is 0 in all other slots and at all times before the first sync.
- R7: Only slots with their `cfg_rx_mask_i` bit set are captured. All other slot fields, and bits above the slot width, read as 0.
- R8: `rx_valid_o` rises after the last bit of a complete frame and stays high with stable data until `rx_ready_i` is 1. A frame completing meanwhile replaces the pending data.
- R9: `tx_ready_o` is 1 only while the holding register is empty. It falls after a frame is accepted and stays low until the next frame start.
- R10: If no transmit frame was accepted before a frame start, the owned slots of that frame send zeros.
- R11: A sync arriving before the programmed frame length has elapsed raises `sync_err_o` for one system clock. The slot count restarts from the sync, the truncated frame is not delivered, and the following frame is received intact.
- R12: A sync at the expected position, and the very first sync after reset, never raise `sync_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock from the link master |
| fsync_i | input | 1 | Frame sync pulse, one bit clock wide |
| rxd_i | input | 1 | Serial receive data |
| txd_o | output | 1 | Serial transmit data |
| txd_oe_o | output | 1 | Transmit line enable, 1 in owned slots |
| cfg_align_b_i | input | 1 | 1: MSB coincides with sync; 0: MSB one bit clock after sync |
| cfg_slots_m1_i | input | $clog2(MAX_SLOTS) | Slots per frame minus one |
| cfg_bits_m1_i | input | $clog2(MAX_W) | Bits per slot minus one |
| cfg_tx_mask_i | input | MAX_SLOTS | Slots this port transmits in |
| cfg_rx_mask_i | input | MAX_SLOTS | Slots this port captures |
| tx_data_i | input | MAX_SLOTS*MAX_W | Transmit frame, slot s at [s*MAX_W +: MAX_W] |
| tx_valid_i | input | 1 | Transmit frame offered |
| tx_ready_o | output | 1 | Holding register empty |
| rx_data_o | output | MAX_SLOTS*MAX_W | Received frame |
| rx_valid_o | output | 1 | Received frame pending |
| rx_ready_i | input | 1 | Consumer takes the received frame |
| sync_err_o | output | 1 | One-clock pulse on an early sync |

## Verification
A wrong bit or slot position shows up in the next delivered receive frame: every slot lands shifted, and the frame vector no longer matches the serial pattern that was driven. An ownership error shows at the first falling bit-clock edge of the affected slot, as the output enable toggling in the wrong bit period. A lost or false lock shows either as a spurious `sync_err_o` pulse at the next sync or as missing `rx_valid_o` frames. The bench therefore counts delivered frames and error pulses for every run, and compares the transmit line bit by bit over each frame.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
  // Where the first data bit sits relative to the sync pulse.
  typedef enum logic {
    ALIGN_AFTER = 1'b0,   // MSB one bit clock after sync
    ALIGN_WITH  = 1'b1    // MSB in the same bit period as sync
  } align_e;

  // Depth of the input synchronizers on the serial wires.
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
  import pcm_tdm_pkg::*;
#(
  parameter int SW = 3,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          sync_i,
  input  align_e        align_i,
  input  logic [SW-1:0] slots_m1_i,
  input  logic [BW-1:0] bits_m1_i,
  output logic [SW-1:0] cur_slot_o,
  output logic [BW-1:0] cur_bit_o,
  output logic [SW-1:0] nxt_slot_o,
  output logic [BW-1:0] nxt_bit_o,
  output logic          smp_en_o,
  output logic          done_o,
  output logic          wrap_o,
  output logic          locked_o,
  output logic          sync_err_o
);
  logic [SW-1:0] nxt_slot_q, sp_slot, inc_slot;
  logic [BW-1:0] nxt_bit_q, sp_bit, inc_bit;
  logic          locked_q, err_q, adv, early, cur_last;

  always_comb begin
    // position the sync edge stands for
    sp_slot = (align_i == ALIGN_WITH) ? '0 : slots_m1_i;
    sp_bit  = (align_i == ALIGN_WITH) ? '0 : bits_m1_i;
    cur_slot_o = sync_i ? sp_slot : nxt_slot_q;
    cur_bit_o  = sync_i ? sp_bit  : nxt_bit_q;
    cur_last   = (cur_slot_o == slots_m1_i) && (cur_bit_o == bits_m1_i);
    adv   = rise_i && (locked_q || sync_i);
    early = rise_i && sync_i && locked_q &&
            ((nxt_slot_q != sp_slot) || (nxt_bit_q != sp_bit));
    smp_en_o = rise_i && (locked_q || (sync_i && align_i == ALIGN_WITH));
    done_o   = smp_en_o && cur_last && !early;
    wrap_o   = adv && cur_last;
    inc_slot = cur_slot_o;
    inc_bit  = cur_bit_o + BW'(1);
    if (cur_bit_o >= bits_m1_i) begin
      inc_bit  = '0;
      inc_slot = (cur_slot_o >= slots_m1_i) ? '0 : cur_slot_o + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_slot_q <= '0;
      nxt_bit_q  <= '0;
      locked_q   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      err_q <= early;
      if (adv) begin
        nxt_slot_q <= inc_slot;
        nxt_bit_q  <= inc_bit;
        locked_q   <= 1'b1;
      end
    end
  end

  assign nxt_slot_o = nxt_slot_q;
  assign nxt_bit_o  = nxt_bit_q;
  assign locked_o   = locked_q;
  assign sync_err_o = err_q;
endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture #(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_W     = 32,
  parameter int SW        = 3,
  parameter int BW        = 5,
  parameter int FW        = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_en_i,
  input  logic                 done_i,
  input  logic [SW-1:0]        cur_slot_i,
  input  logic [BW-1:0]        cur_bit_i,
  input  logic [BW-1:0]        bits_m1_i,
  input  logic [MAX_SLOTS-1:0] mask_i,
  input  logic                 rxd_i,
  output logic [FW-1:0]        rx_data_o,
  output logic                 rx_valid_o,
  input  logic                 rx_ready_i
);
  logic [FW-1:0] work_q, work_nx, out_q;
  logic          valid_q;
  logic [BW-1:0] off;

  always_comb begin
    off     = bits_m1_i - cur_bit_i;
    work_nx = work_q;
    if (cur_bit_i == '0) work_nx[{cur_slot_i, {BW{1'b0}}} +: MAX_W] = '0;
    if (mask_i[cur_slot_i]) work_nx[{cur_slot_i, off}] = rxd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q  <= '0;
      out_q   <= '0;
      valid_q <= 1'b0;
    end else if (done_i) begin
      work_q  <= '0;
      out_q   <= work_nx;
      valid_q <= 1'b1;
    end else begin
      if (smp_en_i) work_q <= work_nx;
      if (valid_q && rx_ready_i) valid_q <= 1'b0;
    end
  end

  assign rx_data_o  = out_q;
  assign rx_valid_o = valid_q;
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int MAX_SLOTS = 8,
  parameter int SW        = 3,
  parameter int BW        = 5,
  parameter int FW        = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall_i,
  input  logic                 wrap_i,
  input  logic                 locked_i,
  input  logic [SW-1:0]        nxt_slot_i,
  input  logic [BW-1:0]        nxt_bit_i,
  input  logic [BW-1:0]        bits_m1_i,
  input  logic [MAX_SLOTS-1:0] mask_i,
  input  logic [FW-1:0]        tx_data_i,
  input  logic                 tx_valid_i,
  output logic                 tx_ready_o,
  output logic                 txd_o,
  output logic                 txd_oe_o
);
  logic [FW-1:0] hold_q, act_q;
  logic          full_q, accept, own, bit_v, txd_q, oe_q;
  logic [BW-1:0] off;

  assign accept = tx_valid_i && !full_q;

  always_comb begin
    off   = bits_m1_i - nxt_bit_i;
    bit_v = act_q[{nxt_slot_i, off}];
    own   = locked_i && mask_i[nxt_slot_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
      full_q <= 1'b0;
      txd_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (wrap_i) begin
        act_q  <= full_q ? hold_q : (accept ? tx_data_i : '0);
        full_q <= 1'b0;
      end else if (accept) begin
        hold_q <= tx_data_i;
        full_q <= 1'b1;
      end
      if (fall_i) begin
        txd_q <= own && bit_v;
        oe_q  <= own;
      end
    end
  end

  assign tx_ready_o = !full_q;
  assign txd_o      = txd_q;
  assign txd_oe_o   = oe_q;
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int MAX_SLOTS = 8,   // power of two, at least 2
  parameter int MAX_W     = 32   // power of two, at least 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bclk_i,
  input  logic                                 fsync_i,
  input  logic                                 rxd_i,
  output logic                                 txd_o,
  output logic                                 txd_oe_o,
  input  logic                                 cfg_align_b_i,
  input  logic [$clog2(MAX_SLOTS)-1:0]         cfg_slots_m1_i,
  input  logic [$clog2(MAX_W)-1:0]             cfg_bits_m1_i,
  input  logic [MAX_SLOTS-1:0]                 cfg_tx_mask_i,
  input  logic [MAX_SLOTS-1:0]                 cfg_rx_mask_i,
  input  logic [MAX_SLOTS*MAX_W-1:0]           tx_data_i,
  input  logic                                 tx_valid_i,
  output logic                                 tx_ready_o,
  output logic [MAX_SLOTS*MAX_W-1:0]           rx_data_o,
  output logic                                 rx_valid_o,
  input  logic                                 rx_ready_i,
  output logic                                 sync_err_o
);
  localparam int SW = $clog2(MAX_SLOTS);
  localparam int BW = $clog2(MAX_W);
  localparam int FW = MAX_SLOTS * MAX_W;

  logic [2:0]    wires_s;
  logic          bclk_q, bclk_rise, bclk_fall;
  logic [SW-1:0] cur_slot, nxt_slot;
  logic [BW-1:0] cur_bit, nxt_bit;
  logic          smp_en, frame_done, wrap, locked;
  align_e        align;

  assign align = align_e'(cfg_align_b_i);

  pcm_edge_sync #(.N(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d_i({rxd_i, fsync_i, bclk_i}), .q_o(wires_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= wires_s[0];
  end
  assign bclk_rise = wires_s[0] && !bclk_q;
  assign bclk_fall = !wires_s[0] && bclk_q;

  pcm_slot_timer #(.SW(SW), .BW(BW)) timer_i (
    .clk(clk), .rst_n(rst_n), .rise_i(bclk_rise), .sync_i(wires_s[1]),
    .align_i(align), .slots_m1_i(cfg_slots_m1_i), .bits_m1_i(cfg_bits_m1_i),
    .cur_slot_o(cur_slot), .cur_bit_o(cur_bit),
    .nxt_slot_o(nxt_slot), .nxt_bit_o(nxt_bit),
    .smp_en_o(smp_en), .done_o(frame_done), .wrap_o(wrap),
    .locked_o(locked), .sync_err_o(sync_err_o)
  );

  pcm_rx_capture #(.MAX_SLOTS(MAX_SLOTS), .MAX_W(MAX_W), .SW(SW), .BW(BW), .FW(FW)) rx_i (
    .clk(clk), .rst_n(rst_n), .smp_en_i(smp_en), .done_i(frame_done),
    .cur_slot_i(cur_slot), .cur_bit_i(cur_bit), .bits_m1_i(cfg_bits_m1_i),
    .mask_i(cfg_rx_mask_i), .rxd_i(wires_s[2]),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i)
  );

  pcm_tx_shifter #(.MAX_SLOTS(MAX_SLOTS), .SW(SW), .BW(BW), .FW(FW)) tx_i (
    .clk(clk), .rst_n(rst_n), .fall_i(bclk_fall), .wrap_i(wrap),
    .locked_i(locked), .nxt_slot_i(nxt_slot), .nxt_bit_i(nxt_bit),
    .bits_m1_i(cfg_bits_m1_i), .mask_i(cfg_tx_mask_i),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .txd_o(txd_o), .txd_oe_o(txd_oe_o)
  );
endmodule

// File: rtl/pcm_tdm_port_chk.sv
module pcm_tdm_port_chk #(
  parameter int FW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bclk_fall,
  input logic          locked,
  input logic          wrap,
  input logic          frame_done,
  input logic          txd_o,
  input logic          txd_oe_o,
  input logic          tx_ready_o,
  input logic          rx_valid_o,
  input logic          rx_ready_i,
  input logic [FW-1:0] rx_data_o,
  input logic          sync_err_o
);
  // R5: serial outputs move only after a falling bit-clock edge
  p_tx_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((txd_o != $past(txd_o)) || (txd_oe_o != $past(txd_oe_o))) |-> $past(bclk_fall));

  // R6: nothing is driven before the first sync
  p_no_drive_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !txd_oe_o);

  // R8: pending frame survives until taken
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o);

  p_rx_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i && !frame_done) |=> $stable(rx_data_o));

  p_rx_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> $past(frame_done));

  // R9: a full holding register stays full until a frame start
  p_tx_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready_o && !wrap) |=> !tx_ready_o);

  // R11: error is a single-clock pulse
  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |=> !sync_err_o);

  // R12: no error before lock
  p_err_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |-> $past(locked));
endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(.FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall), .locked(locked),
  .wrap(wrap), .frame_done(frame_done), .txd_o(txd_o), .txd_oe_o(txd_oe_o),
  .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
  .rx_data_o(rx_data_o), .sync_err_o(sync_err_o)
);

// File: tb/pcm_tdm_port_tb_top.sv
module pcm_tdm_port_tb_top;
  localparam int MS = 8;
  localparam int MW = 32;
  localparam int FW = MS * MW;
  localparam int HALF = 6;   // system clocks per bit-clock half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_i = 1'b0, fsync_i = 1'b0, rxd_i = 1'b0;
  logic txd_o, txd_oe_o, tx_ready_o, rx_valid_o, sync_err_o;
  logic cfg_align_b_i = 1'b0;
  logic [2:0] cfg_slots_m1_i = '0;
  logic [4:0] cfg_bits_m1_i = '0;
  logic [MS-1:0] cfg_tx_mask_i = '0, cfg_rx_mask_i = '0;
  logic [FW-1:0] tx_data_i = '0, rx_data_o;
  logic tx_valid_i = 1'b0, rx_ready_i = 1'b1;

  int checks = 0, fails = 0, err_n = 0;
  bit finished = 0;
  logic [FW-1:0] got_q[$];
  logic [FW-1:0] exp_q[$];

  always #5 clk = ~clk;

  pcm_tdm_port #(.MAX_SLOTS(MS), .MAX_W(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fsync_i(fsync_i), .rxd_i(rxd_i),
    .txd_o(txd_o), .txd_oe_o(txd_oe_o), .cfg_align_b_i(cfg_align_b_i),
    .cfg_slots_m1_i(cfg_slots_m1_i), .cfg_bits_m1_i(cfg_bits_m1_i),
    .cfg_tx_mask_i(cfg_tx_mask_i), .cfg_rx_mask_i(cfg_rx_mask_i),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
    .sync_err_o(sync_err_o)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid_o && rx_ready_i) got_q.push_back(rx_data_o);
    if (rst_n && sync_err_o) err_n++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] rand_frame();
    logic [FW-1:0] r;
    for (int k = 0; k < FW / 32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  // R7: only owned slots, only the low w bits, no slots past the count
  function automatic logic [FW-1:0] exp_rx(logic [FW-1:0] r, int nsl, int w, logic [MS-1:0] m);
    logic [FW-1:0] res = '0;
    for (int s = 0; s < MS; s++)
      for (int b = 0; b < MW; b++)
        if (s < nsl && m[s] && b < w) res[s*MW + b] = r[s*MW + b];
    return res;
  endfunction

  // R4: serial bit i of a frame
  function automatic logic ser_bit(logic [FW-1:0] r, int i, int w);
    return r[(i / w) * MW + (w - 1 - (i % w))];
  endfunction

  task automatic drive_bit(input logic sy, input logic d, output logic tv, output logic ov);
    fsync_i = sy;
    rxd_i   = d;
    repeat (HALF) @(negedge clk);
    bclk_i = 1'b1;
    tv = txd_o;
    ov = txd_oe_o;
    repeat (HALF) @(negedge clk);
    bclk_i = 1'b0;
  endtask

  task automatic run_cfg(input bit mode_b, input int sm1, input int bm1,
                         input logic [MS-1:0] txm, input logic [MS-1:0] rxm,
                         input int nfr, input bit use_tx, input int abort_f,
                         input bit hold_rx, input string name);
    int w = bm1 + 1;
    int nsl = sm1 + 1;
    int n = nsl * w;
    int abort_k = n / 2 + 1;
    logic [FW-1:0] d = rand_frame();
    logic txs[256];
    logic oes[256];
    logic tv, ov;
    got_q.delete();
    exp_q.delete();
    @(negedge clk);
    rst_n = 1'b0;
    tx_valid_i = 1'b0;
    rx_ready_i = !hold_rx;
    bclk_i = 1'b0; fsync_i = 1'b0; rxd_i = 1'b0;
    cfg_align_b_i = mode_b;
    cfg_slots_m1_i = 3'(sm1);
    cfg_bits_m1_i = 5'(bm1);
    cfg_tx_mask_i = txm;
    cfg_rx_mask_i = rxm;
    tx_data_i = d;
    repeat (4) @(negedge clk);
    check(txd_oe_o == 0 && txd_o == 0 && rx_valid_o == 0 && sync_err_o == 0 && tx_ready_o == 1,
          "R1", {name, " reset state"},
          FW'({txd_oe_o, txd_o, rx_valid_o, sync_err_o, tx_ready_o}), FW'(5'b00001));
    rst_n = 1'b1;
    @(negedge clk);
    err_n = 0;
    tx_valid_i = use_tx;
    repeat (3) @(negedge clk);
    check(tx_ready_o == !use_tx, "R9", {name, " ready after offer"},
          FW'(tx_ready_o), FW'(!use_tx));
    if (!mode_b) drive_bit(1'b1, 1'b0, tv, ov);
    for (int f = 0; f < nfr; f++) begin
      logic [FW-1:0] r = rand_frame();
      int nb = (f == abort_f) ? abort_k : n;
      int bad_tx = -1;
      int bad_oe = -1;
      for (int i = 0; i < nb; i++) begin
        logic sy = mode_b ? (i == 0) : (i == nb - 1);
        drive_bit(sy, ser_bit(r, i, w), tv, ov);
        txs[i] = tv;
        oes[i] = ov;
      end
      if (f != abort_f) exp_q.push_back(exp_rx(r, nsl, w, rxm));
      if (f >= 1 && f != abort_f && f != abort_f + 1) begin
        for (int i = 0; i < n; i++) begin
          logic e_oe = txm[i / w];
          logic e_tx = e_oe && use_tx && ser_bit(d, i, w);
          if (oes[i] !== e_oe && bad_oe < 0) bad_oe = i;
          if (e_oe && txs[i] !== e_tx && bad_tx < 0) bad_tx = i;
        end
        check(bad_oe < 0, "R6", {name, " tx enable per slot, first bad bit"},
              FW'(bad_oe), FW'(-1));
        check(bad_tx < 0, use_tx ? "R4" : "R10", {name, " tx data per bit, first bad bit"},
              FW'(bad_tx), FW'(-1));
      end
    end
    repeat (20) @(negedge clk);
    if (hold_rx) begin
      logic [FW-1:0] last = exp_q[$];
      check(rx_valid_o == 1 && rx_data_o == last, "R8", {name, " pending frame replaced"},
            rx_data_o, last);
      exp_q.delete();
      exp_q.push_back(last);
      rx_ready_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    check(got_q.size() == exp_q.size(), abort_f >= 0 ? "R11" : "R8",
          {name, " delivered frame count"}, FW'(got_q.size()), FW'(exp_q.size()));
    for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
      check(got_q[k] == exp_q[k], mode_b ? "R2" : "R3", {name, " received frame (R7 masking)"},
            got_q[k], exp_q[k]);
    check(err_n == (abort_f >= 0 ? 1 : 0), abort_f >= 0 ? "R11" : "R12",
          {name, " sync error pulses"}, FW'(err_n), FW'(abort_f >= 0 ? 1 : 0));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    run_cfg(1, 3, 15, 8'b0000_0101, 8'b1111_1111, 4, 1, -1, 0, "modeB_4x16");
    run_cfg(0, 1, 31, 8'b0000_0011, 8'b0000_0010, 3, 1, -1, 0, "modeA_2x32");
    run_cfg(0, 2, 7,  8'b0000_0110, 8'b0000_0101, 3, 0, -1, 0, "underrun");
    run_cfg(1, 2, 7,  8'b0000_0111, 8'b0000_0111, 4, 1, 1, 0, "early_B");
    run_cfg(0, 3, 5,  8'b0000_1001, 8'b0000_1111, 4, 1, 1, 0, "early_A");
    run_cfg(1, 1, 11, 8'b0000_0010, 8'b0000_0011, 3, 1, -1, 1, "backpressure");
    for (int k = 0; k < 4; k++)
      run_cfg($urandom % 2, $urandom % 8, 3 + $urandom % 13, 8'($urandom),
              8'($urandom), 3, 1, -1, 0, "random");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule